// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block is the write path behind a serial-interface nonvolatile memory. After the command decoder has received a write-array opcode and its address, it sends a start strobe with the address. Each data byte that follows arrives as a single-cycle strobe. The engine stores the bytes in a page buffer of 2^PW bytes. The buffer offset starts at the low bits of the start address and wraps within the page, so a long burst overwrites earlier entries.

When chip select rises, the front end sends a single-cycle event with a flag. The flag is high only when the rise came directly after the last bit of a data byte. The engine commits the page only on an aligned rise with at least one byte buffered. Any other rise throws the buffer away. A commit starts a self-timed write cycle of TWR system clocks, during which `busy` is high. In the first 2^PW clocks of that cycle, the buffered bytes are copied into the internal array. Any byte whose address the protection logic flags is skipped. In the last clock of the cycle, `done` pulses, and the front end uses it to clear its write-enable latch.

A start is honoured only while the write-enable latch is set. The front end sets the latch on a chip-select rise after the enable opcode. A write sent in the same frame as its enable opcode therefore sees the latch still clear and is dropped.

Top module: `page_commit`

## Requirements
- R1: A `wr_start` strobe is accepted only when `wel` is 1 in that cycle and the engine is not busy. A refused start leaves every later byte and chip-select event of that command without effect, so the array is not written.
- R2: Accepted bytes are buffered at consecutive page offsets, beginning at `start_addr[PW-1:0]`. After offset 2^PW-1 the next offset is 0, and a byte sent to an offset already written replaces the older value.
- R3: A `cs_rise` during collection commits only when `cs_aligned` is 1 and at least one byte is buffered. Otherwise the buffer is discarded, `busy` stays 0 and no array write occurs.
- R4: `busy` rises in the cycle after the committing `cs_rise` and stays high for exactly TWR cycles.
- R5: In busy cycle i, for i from 0 to 2^PW-1, `arr_addr` equals {page of the start address, i}. `arr_we` is 1 exactly when offset i holds a buffered byte and `addr_prot` is 0, and `arr_wdata` then carries that byte. `arr_we` is 0 in every other cycle.
- R6: A buffered byte whose address has `addr_prot` high is not written, while the unprotected bytes of the same page are written.
- R7: `done` is high for exactly one cycle per committed write, namely the last cycle in which `busy` is high.
- R8: While busy, `wr_start`, `byte_vld` and `cs_rise` are ignored. No new command is collected, and the cycle in progress is neither lengthened nor cut short.
- R9: After reset `busy`, `done` and `arr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write-array command received, address valid |
| start_addr | input | AW | First byte address of the write |
| wel | input | 1 | Write-enable latch state |
| byte_vld | input | 1 | One data byte received |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip select went high |
| cs_aligned | input | 1 | The rise followed bit 0 of a data byte |
| addr_prot | input | 1 | Address on `arr_addr` lies in a protected segment |
| busy | output | 1 | Self-timed write cycle in progress |
| done | output | 1 | Last cycle of the write cycle; clears the enable latch |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
Every input is sampled at a single clock edge. `busy` is therefore due one edge after the committing `cs_rise`. The write for page offset i appears i cycles later, and `done` appears TWR-1 cycles after `busy` rises. The bench applies each stimulus for one edge and then advances a behavioural model by that same edge. It compares all outputs to the model one time step after every rising edge, so each result is checked in the cycle it is due, and one cycle early or late counts as a mismatch. Array contents, busy length and the number of `done` pulses are then checked at the ports against the values the requirements predict.

// File: rtl/page_commit.sv
module page_commit #(
  parameter int AW  = 13,
  parameter int PW  = 5,
  parameter int TWR = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic [AW-1:0] start_addr,
  input  logic          wel,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          cs_rise,
  input  logic          cs_aligned,
  input  logic          addr_prot,
  output logic          busy,
  output logic          done,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata
);
  localparam int PAGE = 1 << PW;
  localparam int CW   = $clog2(TWR) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_PROG} st_e;

  st_e             st_q;
  logic [AW-PW-1:0] page_q;
  logic [PW-1:0]   off_q;
  logic [PAGE-1:0] vld_q;
  logic [CW-1:0]   cnt_q;
  logic [7:0]      pg_data [PAGE];

  wire in_copy = (cnt_q < CW'(PAGE));
  wire [PW-1:0] slot = cnt_q[PW-1:0];
  wire last = (cnt_q == CW'(TWR-1));

  assign busy      = (st_q == ST_PROG);
  assign done      = busy && last;
  assign arr_addr  = {page_q, slot};
  assign arr_wdata = pg_data[slot];
  assign arr_we    = busy && in_copy && vld_q[slot] && !addr_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      off_q  <= '0;
      vld_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (wr_start && wel) begin
          st_q   <= ST_COLLECT;
          page_q <= start_addr[AW-1:PW];
          off_q  <= start_addr[PW-1:0];
          vld_q  <= '0;
        end
        ST_COLLECT: if (cs_rise) begin
          if (cs_aligned && (|vld_q)) begin
            st_q  <= ST_PROG;
            cnt_q <= '0;
          end else begin
            st_q <= ST_IDLE;
          end
        end else if (byte_vld) begin
          vld_q[off_q] <= 1'b1;
          off_q        <= off_q + 1'b1;
        end
        ST_PROG: if (last) st_q <= ST_IDLE;
                 else      cnt_q <= cnt_q + 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_COLLECT && !cs_rise && byte_vld) pg_data[off_q] <= byte_data;
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R5
  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !addr_prot); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R4
  AST_RISE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_aligned)); // R3
  AST_ADDR_STEADY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr[AW-1:PW])); // R8
endmodule

// File: tb/test_page_commit.sv
`timescale 1ns/1ps
module test_page_commit;
  localparam int AW = 13;
  localparam int TWR = 40;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, wel = 0, byte_vld = 0, cs_rise = 0, cs_aligned = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic prot_en = 0;
  logic [AW-1:0] prot_lo = '0;
  logic addr_prot, busy, done, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  assign addr_prot = prot_en && (arr_addr >= prot_lo);

  page_commit #(.AW(AW), .PW(5), .TWR(TWR)) i_page_commit (
    .clk, .rst_n, .wr_start, .start_addr, .wel, .byte_vld, .byte_data,
    .cs_rise, .cs_aligned, .addr_prot, .busy, .done, .arr_we, .arr_addr, .arr_wdata);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R9";
  int mem [8192];
  int m_data [32];
  bit m_busy = 0, m_col = 0;
  int m_cnt = 0, m_page = 0, m_off = 0;
  int busy_cycles = 0, done_count = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit prot_of(int a);
    return prot_en && (a >= int'(prot_lo));
  endfunction

  task automatic model_step();
    bit any;
    if (!rst_n) begin m_busy = 0; m_col = 0; m_cnt = 0; end
    else if (m_busy) begin
      if (m_cnt == TWR-1) m_busy = 0; else m_cnt++;
    end else if (m_col) begin
      if (cs_rise) begin
        any = 0;
        foreach (m_data[i]) if (m_data[i] >= 0) any = 1;
        m_col = 0;
        if (cs_aligned && any) begin m_busy = 1; m_cnt = 0; end
      end else if (byte_vld) begin
        m_data[m_off] = int'(byte_data);
        m_off = (m_off + 1) % 32;
      end
    end else if (wr_start && wel) begin
      m_col = 1; m_page = int'(start_addr) / 32; m_off = int'(start_addr) % 32;
      foreach (m_data[i]) m_data[i] = -1;
    end
  endtask

  task automatic cyc();
    bit e_busy, e_done, e_we;
    int e_addr, e_dat, act, exp;
    @(posedge clk); #1;
    cycles++;
    model_step();
    e_busy = m_busy;
    e_done = m_busy && (m_cnt == TWR-1);
    e_addr = m_page * 32 + m_cnt;
    e_we   = m_busy && (m_cnt < 32) && (m_data[m_cnt % 32] >= 0) && !prot_of(e_addr);
    e_dat  = m_data[m_cnt % 32];
    act = {busy, done, arr_we};
    exp = {e_busy, e_done, e_we};
    if (act !== exp) chk(0, cur_req, act, exp);
    else if (e_we && (int'(arr_addr) != e_addr || int'(arr_wdata) != e_dat))
      chk(0, cur_req, {arr_addr, arr_wdata}, (e_addr << 8) | e_dat);
    else chk(1, cur_req, 0, 0);
    if (arr_we === 1'b1) mem[arr_addr] = int'(arr_wdata);
    if (busy === 1'b1) busy_cycles++;
    if (done === 1'b1) done_count++;
    wr_start = 0; byte_vld = 0; cs_rise = 0; cs_aligned = 0;
  endtask

  task automatic send(int addr, int n, int first, bit aligned, bit en);
    wr_start = 1; start_addr = AW'(addr); wel = en; cyc();
    for (int i = 0; i < n; i++) begin byte_vld = 1; byte_data = 8'(first + i); cyc(); end
    cs_rise = 1; cs_aligned = aligned; cyc();
  endtask

  task automatic settle();
    for (int i = 0; i < TWR + 40 && m_busy; i++) cyc();
    cyc(); cyc();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    foreach (mem[i]) mem[i] = -1;
    foreach (m_data[i]) m_data[i] = -1;
    cyc(); cyc();
    chk(busy === 0 && done === 0 && arr_we === 0, "R9", {busy, done, arr_we}, 0);
    rst_n = 1; cyc();

    cur_req = "R1"; busy_cycles = 0;
    send('h0200, 2, 'h44, 1, 0); settle();
    chk(mem['h200] == -1, "R1", mem['h200], -1);
    chk(busy_cycles == 0, "R1", busy_cycles, 0);

    cur_req = "R5"; busy_cycles = 0; done_count = 0;
    send('h0123, 1, 'h5A, 1, 1); settle();
    chk(mem['h123] == 'h5A, "R5", mem['h123], 'h5A);
    chk(mem['h124] == -1, "R5", mem['h124], -1);
    chk(busy_cycles == TWR, "R4", busy_cycles, TWR);
    chk(done_count == 1, "R7", done_count, 1);

    cur_req = "R2";
    send('h0A1E, 3, 'h10, 1, 1); settle();
    chk(mem['hA1E] == 'h10, "R2", mem['hA1E], 'h10);
    chk(mem['hA1F] == 'h11, "R2", mem['hA1F], 'h11);
    chk(mem['hA00] == 'h12, "R2", mem['hA00], 'h12);
    chk(mem['hA20] == -1, "R2", mem['hA20], -1);
    send('h0040, 34, 'h80, 1, 1); settle();
    chk(mem['h40] == 'hA0, "R2", mem['h40], 'hA0);
    chk(mem['h41] == 'hA1, "R2", mem['h41], 'hA1);
    chk(mem['h42] == 'h82, "R2", mem['h42], 'h82);
    chk(mem['h5F] == 'h9F, "R2", mem['h5F], 'h9F);

    cur_req = "R3"; busy_cycles = 0;
    send('h0300, 1, 'h77, 0, 1); settle();
    chk(mem['h300] == -1, "R3", mem['h300], -1);
    send('h0310, 0, 0, 1, 1); settle();
    chk(busy_cycles == 0, "R3", busy_cycles, 0);

    cur_req = "R6"; prot_en = 1; prot_lo = AW'('h1F10);
    send('h1F0E, 4, 'hC0, 1, 1); settle();
    chk(mem['h1F0E] == 'hC0, "R6", mem['h1F0E], 'hC0);
    chk(mem['h1F0F] == 'hC1, "R6", mem['h1F0F], 'hC1);
    chk(mem['h1F10] == -1, "R6", mem['h1F10], -1);
    chk(mem['h1F11] == -1, "R6", mem['h1F11], -1);
    prot_en = 0; cyc();

    cur_req = "R8"; busy_cycles = 0; done_count = 0;
    send('h0500, 1, 'h33, 1, 1);
    cyc(); cyc();
    wr_start = 1; start_addr = AW'('h0600); wel = 1; cyc();
    byte_vld = 1; byte_data = 8'h66; cyc();
    cs_rise = 1; cs_aligned = 1; cyc();
    settle();
    chk(mem['h500] == 'h33, "R8", mem['h500], 'h33);
    chk(mem['h600] == -1, "R8", mem['h600], -1);
    chk(busy_cycles == TWR, "R8", busy_cycles, TWR);
    chk(done_count == 1, "R7", done_count, 1);

    summary();
  end
endmodule